// File: doc/BRIEF.md
# Free-Running Timer with Control/Status Register

This block is a 16-bit up-counter that runs off the system clock through a selectable power-of-two prescaler. Software controls it through a small synchronous register bus with two locations. One is an 8-bit control/status byte. The other is a 16-bit counter data word that can be read at any time and written to preload the count.

The control byte holds an overflow/match flag, an interrupt enable, a stop bit, a compare-restart mode bit, a self-clearing restart bit and a 3-bit rate select. The flag is sticky. Writing 0 to it clears it, and writing 1 to it leaves it alone. During a read-modify-write access it reads as 1, so a read-modify-write of some other field can never clear a pending flag by accident. Two match inputs come from external compare channels. When the mode bit is set, a pulse on either input restarts the counter at zero and raises the flag.

Top module: `freerun_timer`

## Requirements
- R1: After reset the control byte reads 0x00 and `irq` is low.
- R2: Byte address 0 selects the 16-bit counter word. Byte address 2 selects the control byte, which has flag at bit 7, enable at bit 6, stop at bit 5, mode at bit 4, restart at bit 3 and rate select at bits 2..0.
- R3: A control write with bit 7 = 0 clears the flag. A control write with bit 7 = 1 leaves the flag unchanged.
- R4: A control-byte read with `bus_rmw` high returns bit 7 as 1 whatever the flag holds.
- R5: A count step taken at 0xFFFF wraps the counter to 0x0000 and sets the flag.
- R6: `irq` is high exactly when both the flag and the enable bit are 1.
- R7: With stop = 1 the counter holds its value. With stop = 0 it steps once per prescaler tick.
- R8: Rate select value s gives one count step every 2^s clock cycles (s = 0..7), and a new value applies from the cycle after the write.
- R9: With mode = 1, a pulse on `cmp0_match` or `cmp4_match` restarts the counter at 0 and sets the flag. With mode = 0 these inputs change neither the counter nor the flag.
- R10: Writing 1 to the restart bit forces the counter to 0 on the write cycle, ahead of any count step in that cycle. The bit always reads back as 0.
- R11: A write to the counter word loads the written value, ahead of any count step in that cycle.
- R12: `bus_rdata` presents the addressed register one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rmw | input | 1 | Marks the access as the read half of a read-modify-write |
| bus_rdata | output | DATA_W | Registered read data |
| cmp0_match | input | 1 | Match pulse from compare channel 0 |
| cmp4_match | input | 1 | Match pulse from compare channel 4 |
| irq | output | 1 | Interrupt request (flag AND enable) |

## Verification
The count path is tried three ways. Stop/run windows at rate select 0 confirm one step per cycle. Windows of 64 or 256 cycles at selects 1, 3 and 7 show each divider tap, and a wrong tap gives a different multiple. A preload near 0xFFFF separates a correct wrap-plus-flag from a saturating or flagless counter. Match pulses are applied with the mode bit in each state, to show that restart and flag depend on that bit. Back-to-back writes place a restart or a preload in the same cycle as a count step, which exposes the wrong priority order. Reads with and without the read-modify-write qualifier show the flag masking.

// File: rtl/frt_pkg.sv
package frt_pkg;
  // register byte offsets
  localparam int OFS_COUNT = 0;
  localparam int OFS_CTRL  = 2;
  // rate-select field width; prescaler depth follows from it
  localparam int RATE_W    = 3;
  // control byte bit positions
  localparam int B_FLAG  = 7;
  localparam int B_IEN   = 6;
  localparam int B_HALT  = 5;
  localparam int B_MODE  = 4;
  localparam int B_RST   = 3;

  typedef struct packed {
    logic              flag;
    logic              ien;
    logic              halt;
    logic              mode;
    logic              restart;
    logic [RATE_W-1:0] rate;
  } ctrl_byte_t;
endpackage

// File: rtl/frt_prescale.sv
module frt_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (2 ** SEL_W) - 1;
  localparam logic [DIV_W-1:0] ONES = '1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic [SEL_W:0]   shamt;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  always_comb begin
    shamt = (SEL_W + 1)'(DIV_W) - {1'b0, sel};
    mask  = ONES >> shamt;
    tick  = ((div_q & mask) == mask);
  end

  AST_TICK_DIV1: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |-> tick); // R8
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick && sel != '0) |=> (!tick || sel != $past(sel))); // R8
endmodule

// File: rtl/frt_count.sv
module frt_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         ovf
);
  always_comb ovf = inc && !clr && !load && (count == '1);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (clr)  count <= '0;
    else if (load) count <= load_val;
    else if (inc)  count <= count + 1'b1;
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr && !load) |=> $stable(count)); // R7
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0)); // R10
  AST_WRAP: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (count == '0)); // R5
endmodule

// File: rtl/frt_ctrl.sv
module frt_ctrl
  import frt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [7:0]        wbyte,
  input  logic              cmp_a,
  input  logic              cmp_b,
  input  logic              ovf,
  output logic              flag,
  output logic              ien,
  output logic              halt,
  output logic              mode,
  output logic [RATE_W-1:0] rate,
  output logic              restart,
  output logic              cmp_clr,
  output logic              irq
);
  logic flag_d, ien_d;

  always_comb begin
    cmp_clr = mode && (cmp_a || cmp_b);
    restart = wr && wbyte[B_RST];
    if (ovf || cmp_clr)            flag_d = 1'b1;
    else if (wr && !wbyte[B_FLAG]) flag_d = 1'b0;
    else                           flag_d = flag;
    ien_d = wr ? wbyte[B_IEN] : ien;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      ien  <= 1'b0;
      halt <= 1'b0;
      mode <= 1'b0;
      rate <= '0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_d;
      ien  <= ien_d;
      irq  <= flag_d && ien_d;
      if (wr) begin
        halt <= wbyte[B_HALT];
        mode <= wbyte[B_MODE];
        rate <= wbyte[RATE_W-1:0];
      end
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !(wr && !wbyte[B_FLAG])) |=> flag); // R3
  AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    ovf |=> flag); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag && ien)); // R6
  AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    cmp_clr |=> flag); // R9
endmodule

// File: rtl/freerun_timer.sv
module freerun_timer
  import frt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rmw,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cmp0_match,
  input  logic              cmp4_match,
  output logic              irq
);
  logic              sel_count, sel_ctrl;
  logic              wr_ctrl, wr_count;
  logic              flag, ien, halt, mode, restart, cmp_clr;
  logic [RATE_W-1:0] rate;
  logic              tick, step, clr_any, ovf;
  logic [CNT_W-1:0]  count;
  ctrl_byte_t        ctrl_view;

  always_comb begin
    sel_count = (bus_addr == ADDR_W'(OFS_COUNT));
    sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
    wr_count  = bus_we && sel_count;
    wr_ctrl   = bus_we && sel_ctrl;
    step      = tick && !halt;
    clr_any   = restart || cmp_clr;
  end

  frt_prescale #(.SEL_W(RATE_W)) u_prescale (
    .clk  (clk),
    .rst  (rst),
    .sel  (rate),
    .tick (tick)
  );

  frt_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr      (wr_ctrl),
    .wbyte   (bus_wdata[7:0]),
    .cmp_a   (cmp0_match),
    .cmp_b   (cmp4_match),
    .ovf     (ovf),
    .flag    (flag),
    .ien     (ien),
    .halt    (halt),
    .mode    (mode),
    .rate    (rate),
    .restart (restart),
    .cmp_clr (cmp_clr),
    .irq     (irq)
  );

  frt_count #(.W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr_any),
    .load     (wr_count),
    .load_val (bus_wdata[CNT_W-1:0]),
    .inc      (step),
    .count    (count),
    .ovf      (ovf)
  );

  always_comb begin
    ctrl_view.flag    = flag || bus_rmw;
    ctrl_view.ien     = ien;
    ctrl_view.halt    = halt;
    ctrl_view.mode    = mode;
    ctrl_view.restart = 1'b0;
    ctrl_view.rate    = rate;
  end

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (sel_ctrl)  bus_rdata <= DATA_W'(ctrl_view);
    else if (sel_count) bus_rdata <= DATA_W'(count);
    else                bus_rdata <= '0;
  end

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (wr_count && !clr_any) |=> (count == $past(bus_wdata[CNT_W-1:0]))); // R11
  AST_RMW_FLAG_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rmw && sel_ctrl) |=> bus_rdata[B_FLAG]); // R4
  AST_MODE_OFF_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!mode && !restart && !wr_count && !step) |=> $stable(count)); // R9
endmodule

// File: tb/test_freerun_timer.sv
module test_freerun_timer;
  logic        clk = 0;
  logic        rst = 1;
  logic        bus_we = 0;
  logic [3:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic        bus_rmw = 0;
  logic [15:0] bus_rdata;
  logic        cmp0_match = 0;
  logic        cmp4_match = 0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_req = 0;
  logic        armed = 0;

  always #2.5 clk = ~clk;

  freerun_timer i_freerun_timer (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rmw(bus_rmw), .bus_rdata(bus_rdata),
    .cmp0_match(cmp0_match), .cmp4_match(cmp4_match), .irq(irq)
  );

  // monitor: compares each read result one clock after its address (R12)
  always @(posedge clk) armed <= rd_req;
  always @(negedge clk) begin
    if (armed) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (bus_rdata !== e) begin
        bad++;
        $display("FAIL %s: rdata actual=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr_reg(input int a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = 4'(a); bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic rd_chk(input int a, input logic rmw, input logic [15:0] e, input string t);
    @(negedge clk);
    bus_addr = 4'(a); bus_rmw = rmw; rd_req = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    rd_req = 0; bus_rmw = 0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s: irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  task automatic pulse(input logic a, input logic b);
    @(negedge clk);
    cmp0_match = a; cmp4_match = b;
    @(posedge clk); #1;
    cmp0_match = 0; cmp4_match = 0;
  endtask

  // stopped preload, run window of n cycles at rate select s, stop again
  task automatic run_window(input logic [15:0] v, input logic [2:0] s, input int n);
    wr_reg(0, v);
    wr_reg(2, {8'h0, 8'h80 | {5'b0, s}});
    repeat (n - 1) @(posedge clk);
    wr_reg(2, {8'h0, 8'hA0 | {5'b0, s}});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;

    rd_chk(2, 0, 16'h0000, "R1 reset ctrl");
    chk_irq(0, "R1 reset irq");

    wr_reg(2, 16'h00A0);                       // stop, flag bit 1 = keep
    rd_chk(2, 0, 16'h0020, "R2 ctrl layout stop bit5");
    wr_reg(0, 16'h1234);
    rd_chk(0, 0, 16'h1234, "R11 preload while stopped");
    repeat (20) @(posedge clk);
    rd_chk(0, 0, 16'h1234, "R7 hold while stopped");

    run_window(16'h1234, 3'd0, 10);
    rd_chk(0, 0, 16'h123E, "R7 one step per cycle");
    run_window(16'h0100, 3'd3, 64);
    rd_chk(0, 0, 16'h0108, "R8 select 3 divides by 8");
    run_window(16'h0100, 3'd7, 256);
    rd_chk(0, 0, 16'h0102, "R8 select 7 divides by 128");
    run_window(16'h0100, 3'd1, 64);
    rd_chk(0, 0, 16'h0120, "R8 select 1 divides by 2");

    run_window(16'hFFFE, 3'd0, 3);
    rd_chk(0, 0, 16'h0001, "R5 wrap through 0xFFFF");
    rd_chk(2, 0, 16'h00A0, "R5 overflow sets flag");
    chk_irq(0, "R6 irq low with enable 0");
    wr_reg(2, 16'h00E0);
    chk_irq(1, "R6 irq high with flag and enable");
    rd_chk(2, 0, 16'h00E0, "R3 write 1 keeps flag");
    wr_reg(2, 16'h0060);
    rd_chk(2, 0, 16'h0060, "R3 write 0 clears flag");
    chk_irq(0, "R6 irq low after flag clear");
    rd_chk(2, 1, 16'h00E0, "R4 rmw read shows flag 1");
    rd_chk(2, 0, 16'h0060, "R4 plain read shows real flag");

    wr_reg(2, 16'h0030);                       // stop, mode 1, flag clear
    wr_reg(0, 16'h0055);
    pulse(1, 0);
    rd_chk(0, 0, 16'h0000, "R9 cmp0 restarts counter");
    rd_chk(2, 0, 16'h00B0, "R9 cmp0 sets flag");
    wr_reg(2, 16'h0030);
    wr_reg(0, 16'h0077);
    pulse(0, 1);
    rd_chk(0, 0, 16'h0000, "R9 cmp4 restarts counter");
    rd_chk(2, 0, 16'h00B0, "R9 cmp4 sets flag");
    wr_reg(2, 16'h0020);                       // mode 0, flag clear
    wr_reg(0, 16'h0099);
    pulse(1, 1);
    rd_chk(0, 0, 16'h0099, "R9 mode 0 ignores match count");
    rd_chk(2, 0, 16'h0020, "R9 mode 0 ignores match flag");

    wr_reg(0, 16'h4321);
    wr_reg(2, 16'h00A8);                       // restart, stay stopped
    rd_chk(0, 0, 16'h0000, "R10 restart bit zeroes counter");
    rd_chk(2, 0, 16'h0020, "R10 restart bit reads 0");
    wr_reg(0, 16'h0500);
    wr_reg(2, 16'h0088);                       // run + restart same cycle
    wr_reg(2, 16'h00A0);
    rd_chk(0, 0, 16'h0001, "R10 restart beats count step");
    wr_reg(2, 16'h0080);                       // run
    wr_reg(0, 16'h0700);                       // load while counting
    wr_reg(2, 16'h00A0);
    rd_chk(0, 0, 16'h0701, "R11 load beats count step");

    repeat (3) @(posedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule